// File: doc/BRIEF.md
# Eight-Channel Dual-Resolution PWM Bank

This block holds eight independent pulse-width modulators behind a small register bus. Every channel owns an 8-bit duty value, a 3-bit configuration word and one bit of a shared enable word. A channel that is switched on runs its own frame counter. The counter advances once per PWM clock, and that clock is derived from the block clock by a per-channel power-of-two prescaler. The pin is driven high for the first M PWM clocks of each frame and low for the rest of the frame. A channel that is switched off passes its bit of an external port latch straight to its pin.

Each channel picks a coarse mode (32-clock frame, low 5 duty bits used) or a fine mode (256-clock frame, all 8 duty bits used). It can change mode at run time. A duty value written mid-frame is held back until the next frame boundary, so the waveform never shows a partial frame. The block clock stands for the fastest PWM rate, which is twice the system rate. The prescale codes 0 to 3 therefore tick the counter every 1, 2, 4 or 8 block clocks. The reset input is asserted asynchronously and released in step with the clock.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero, and every pin equals its bit of `port_latch`.
- R2: While a channel's enable bit is 0, its pin equals its bit of `port_latch` in the same cycle.
- R3: While enabled with effective duty M, the pin is high for PWM clocks 0..M-1 of each frame and low for the rest of the frame. M=0 gives a constant low.
- R4: With configuration bit 2 clear (fine mode), a frame lasts 256 PWM clocks and all 8 duty bits are compared.
- R5: With configuration bit 2 set (coarse mode), a frame lasts 32 PWM clocks and only duty bits 4:0 are compared.
- R6: Configuration bits 1:0 = p make the frame counter advance once every 2^p block clocks: 1, 2, 4 or 8.
- R7: A configuration register stores only bits 2:0. Bits 7:3 read as zero whatever was written.
- R8: A duty write takes effect at the first frame boundary after the write edge. A write on the same edge as a boundary takes effect one frame later.
- R9: When a channel's enable bit goes from 0 to 1, its frame counter and prescaler restart from zero. The first PWM clock after the enabling edge is clock 0 of a new frame.
- R10: Register map: address bits 4:3 = 0 selects duty register [2:0], = 1 selects configuration register [2:0], and address 16 is the enable word (bit i for channel i). Reads are combinational, and unmapped addresses read zero.
- R11: Channels run independently. Each channel's pin depends only on its own registers and latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the fastest PWM rate |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| port_latch | input | 8 | Port latch values used by disabled channels |
| pwm_pin | output | 8 | Channel pin outputs |

## Verification
The case that needs care is a duty write that lands on the same clock edge as a frame boundary. On that edge the register takes the new value while the comparator reloads from the old one. The bench places a write in the last block cycle of a frame, which makes the two edges coincide, and then expects the old duty for a full extra frame. A second run writes one cycle earlier and expects the new duty from the very next frame. Every sample of these runs is compared against an arithmetic model of counter position and frame index, and the other pins are checked against the latch at the same time.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int PS_W   = 2;
  localparam int PSC_W  = (1 << PS_W) - 1;
  localparam int LO_W   = 5;

  typedef struct packed {
    logic            res5;
    logic [PS_W-1:0] psel;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int AW  = 5
) (
  input  logic                     clk,
  input  logic                     rst_ns,
  input  logic                     wr_en,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic [NCH-1:0][DW-1:0]   data_q,
  output chan_cfg_t [NCH-1:0]      cfg_q,
  output logic [NCH-1:0]           en_q
);
  localparam int CH_AW = AW - 2;

  reg_sel_e              sel;
  logic [CH_AW-1:0]      idx;
  logic [NCH-1:0][DW-1:0] data_n;
  chan_cfg_t [NCH-1:0]   cfg_n;
  logic [NCH-1:0]        en_n;

  assign sel = reg_sel_e'(addr[AW-1 -: 2]);
  assign idx = addr[CH_AW-1:0];

  always_comb begin
    data_n = data_q;
    cfg_n  = cfg_q;
    en_n   = en_q;
    if (wr_en) begin
      case (sel)
        SEL_DATA: data_n[idx] = wdata;
        SEL_CFG:  cfg_n[idx]  = chan_cfg_t'(wdata[CFG_W-1:0]);
        SEL_EN:   if (idx == '0) en_n = wdata[NCH-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      data_q <= '0;
      cfg_q  <= '0;
      en_q   <= '0;
    end else begin
      data_q <= data_n;
      cfg_q  <= cfg_n;
      en_q   <= en_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_DATA: rdata = data_q[idx];
      SEL_CFG:  rdata[CFG_W-1:0] = cfg_q[idx];
      SEL_EN:   if (idx == '0) rdata[NCH-1:0] = en_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          en,
  input  chan_cfg_t     cfg,
  input  logic [DW-1:0] duty,
  input  logic          latch,
  output logic          pin,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] act_o,
  output logic          tick_o,
  output logic          bnd_o
);
  logic [PSC_W-1:0] psc_q, psc_n, psc_lim;
  logic [DW-1:0]    cnt_q, cnt_n;
  logic [DW-1:0]    act_q, act_n;
  logic [DW-1:0]    mval;
  logic             tick, last, bnd;

  always_comb begin
    psc_lim = ~({PSC_W{1'b1}} << cfg.psel);
    tick    = en && (psc_q == psc_lim);
    last    = cfg.res5 ? (cnt_q[LO_W-1:0] == '1) : (cnt_q == '1);
    bnd     = tick && last;
    if (!en) begin
      psc_n = '0;
      cnt_n = '0;
      act_n = duty;
    end else begin
      psc_n = tick ? '0 : psc_q + 1'b1;
      cnt_n = tick ? (last ? '0 : cnt_q + 1'b1) : cnt_q;
      act_n = bnd ? duty : act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      psc_q <= '0;
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      psc_q <= psc_n;
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end

  always_comb begin
    mval = cfg.res5 ? DW'(act_q[LO_W-1:0]) : act_q;
    pin  = en ? (cnt_q < mval) : latch;
  end

  assign cnt_o  = cnt_q;
  assign act_o  = act_q;
  assign tick_o = tick;
  assign bnd_o  = bnd;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int AW  = $clog2(NCH) + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [NCH-1:0] port_latch,
  output logic [NCH-1:0] pwm_pin
);
  logic [1:0]             rs_q;
  logic                   rst_ns;
  logic [NCH-1:0][DW-1:0] data_q;
  chan_cfg_t [NCH-1:0]    cfg_q;
  logic [NCH-1:0]         en_q;
  logic [NCH-1:0]         ch_res5;
  logic [NCH-1:0][DW-1:0] ch_cnt;
  logic [NCH-1:0][DW-1:0] ch_act;
  logic [NCH-1:0]         ch_tick;
  logic [NCH-1:0]         ch_bnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  pwm_bank_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk    (clk),
    .rst_ns (rst_ns),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .data_q (data_q),
    .cfg_q  (cfg_q),
    .en_q   (en_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_res5[i] = cfg_q[i].res5;
    pwm_bank_chan #(.DW(DW)) u_chan (
      .clk    (clk),
      .rst_ns (rst_ns),
      .en     (en_q[i]),
      .cfg    (cfg_q[i]),
      .duty   (data_q[i]),
      .latch  (port_latch[i]),
      .pin    (pwm_pin[i]),
      .cnt_o  (ch_cnt[i]),
      .act_o  (ch_act[i]),
      .tick_o (ch_tick[i]),
      .bnd_o  (ch_bnd[i])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int AW  = 5
) (
  input logic                   clk,
  input logic                   rst_ns,
  input logic [NCH-1:0]         en_q,
  input logic [NCH-1:0]         ch_res5,
  input logic [NCH-1:0][DW-1:0] ch_cnt,
  input logic [NCH-1:0][DW-1:0] ch_act,
  input logic [NCH-1:0]         ch_tick,
  input logic [NCH-1:0]         ch_bnd,
  input logic [NCH-1:0]         pwm_pin,
  input logic [NCH-1:0]         port_latch,
  input logic [AW-1:0]          addr,
  input logic [DW-1:0]          rdata
);
  // R7
  cfg_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (addr[AW-1 -: 2] == 2'd1) |-> (rdata[DW-1:3] == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R2
    off_latch_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      !en_q[i] |-> (pwm_pin[i] == port_latch[i]));
    // R3
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (en_q[i] && ch_act[i] == '0) |-> !pwm_pin[i]);
    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      $rose(en_q[i]) |-> (ch_cnt[i] == '0));
    // R8
    hold_duty_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (en_q[i] && !ch_bnd[i]) |=> $stable(ch_act[i]));
    // R6
    hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (en_q[i] && !ch_tick[i]) |=> $stable(ch_cnt[i]));
    // R5
    wrap_short_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (en_q[i] && ch_res5[i] && ch_tick[i] && ch_cnt[i][4:0] == 5'h1f) |=> (ch_cnt[i] == '0));
    // R4
    wrap_long_chk: assert property (@(posedge clk) disable iff (!rst_ns)
      (en_q[i] && !ch_res5[i] && ch_tick[i] && ch_cnt[i] == '1) |=> (ch_cnt[i] == '0));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .en_q       (en_q),
  .ch_res5    (ch_res5),
  .ch_cnt     (ch_cnt),
  .ch_act     (ch_act),
  .ch_tick    (ch_tick),
  .ch_bnd     (ch_bnd),
  .pwm_pin    (pwm_pin),
  .port_latch (port_latch),
  .addr       (addr),
  .rdata      (rdata)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [4:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [7:0] port_latch;
  logic [7:0] pwm_pin;
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pwm_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .port_latch(port_latch), .pwm_pin(pwm_pin)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = 5'(a);
    #1;
    chk(rdata, exp, tag);
  endtask

  task automatic run(input int ch, input logic [7:0] m0, input logic [2:0] ctl,
                     input int ncyc, input int kw, input logic [7:0] m1,
                     input logic [7:0] lat, input string tag);
    int div, fr, p, f, c;
    logic [7:0] mu, me, e;
    port_latch = lat;
    wr(ch, m0);
    wr(8 + ch, {5'b0, ctl});
    wr(16, 8'(1 << ch));
    for (int k = 0; k < ncyc; k++) begin
      div = 1 << ctl[1:0];
      fr  = ctl[2] ? 32 : 256;
      p   = k / div;
      f   = p / fr;
      c   = p % fr;
      mu  = (kw >= 0 && f * fr * div >= kw + 2) ? m1 : m0;
      me  = ctl[2] ? (mu & 8'h1f) : mu;
      e   = lat;
      e[ch] = (c < int'(me));
      chk(pwm_pin, e, tag);
      if (k == kw) begin
        wr_en = 1'b1; addr = 5'(ch); wdata = m1;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    wr(16, 8'h00);
    chk(pwm_pin, lat, "R2 after disable");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] e;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; port_latch = 8'h5A;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(pwm_pin, 8'h5A, "R1 pins");
    for (int a = 0; a < 17; a++) rd(a, 8'h00, "R1 regs");
    port_latch = 8'hC3;
    #1 chk(pwm_pin, 8'hC3, "R2 latch follow");

    // R7: configuration upper bits
    wr(11, 8'hFF);
    rd(11, 8'h07, "R7 cfg mask");
    wr(11, 8'h00);
    rd(11, 8'h00, "R7 cfg clear");
    // R10: map and readback
    wr(3, 8'hC3);
    rd(3, 8'hC3, "R10 duty readback");
    rd(24, 8'h00, "R10 unmapped");
    wr(3, 8'h00);
    wr(16, 8'h81);
    rd(16, 8'h81, "R10 enable readback");
    port_latch = 8'hFF;
    #1 chk(pwm_pin, 8'h7E, "R3 zero duty low");
    wr(16, 8'h00);

    // R3 R4: fine mode, fastest divider
    run(0, 8'h40, 3'b000, 520, -1, 8'h00, 8'hF0, "R4 fine m40");
    run(1, 8'h00, 3'b001, 600, -1, 8'h00, 8'hFF, "R3 zero duty");
    run(2, 8'hFF, 3'b000, 520, -1, 8'h00, 8'h0F, "R3 full duty");
    // R5: coarse mode uses low 5 bits
    run(3, 8'hE5, 3'b100, 100, -1, 8'h00, 8'hAA, "R5 coarse masked");
    run(4, 8'h3F, 3'b110, 300, -1, 8'h00, 8'h55, "R5 R6 coarse div4");
    run(1, 8'hE0, 3'b100, 70,  -1, 8'h00, 8'hFF, "R5 masked to zero");
    // R6: slowest prescale in fine mode
    run(7, 8'h80, 3'b011, 4200, -1, 8'h00, 8'h3C, "R6 fine div8");
    // R8: mid-frame, pre-boundary and coincident duty writes
    run(5, 8'h10, 3'b111, 600, 100, 8'h03, 8'h00, "R8 mid-frame");
    run(0, 8'h0C, 3'b100, 100, 30,  8'h14, 8'h81, "R8 pre-boundary");
    run(6, 8'h08, 3'b101, 220, 63,  8'h1A, 8'h24, "R8 coincident");
    // R9: re-enable restarts from frame start (channel 0 reused)
    run(0, 8'h05, 3'b010, 60, -1, 8'h00, 8'h00, "R9 restart");

    // R11: two channels at once with different modes
    port_latch = 8'h99;
    wr(1, 8'h03); wr(9, 8'h04);
    wr(2, 8'h80); wr(10, 8'h00);
    wr(16, 8'h06);
    for (int k = 0; k < 300; k++) begin
      e = 8'h99;
      e[1] = (k % 32) < 3;
      e[2] = (k % 256) < 128;
      chk(pwm_pin, e, "R11 independent");
      @(negedge clk);
    end
    wr(16, 8'h00);
    chk(pwm_pin, 8'h99, "R2 final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule